// File: doc/BRIEF.md
# Serial Stripe Pattern Checker

This block watches a 32-bit word that arrives one bit per clock, least significant bit first, and after every bit reports whether the bits seen so far can still be the start of a uniform stripe pattern. A stripe pattern begins with a run of ones at bit 0. It then alternates runs of zeros and ones, and every run has the same length. The last run may be cut short by the end of the word.

The stripe width is not fixed in advance. The block learns it from the first unbroken run of ones. Every later run, of zeros or of ones, must repeat that length exactly. A start pulse marks the first bit of each word and clears all earlier state. Once any bit breaks the pattern, the match flag stays low until the next start pulse.

Top module: `stripe_checker`

## Requirements
- R1: After reset the match output is 0, and it stays 0 for any serial bits presented before the first start pulse.
- R2: A word whose bit 0 (the bit presented with start high) is 0 never matches: the output is 0 after that bit and after every later bit of the word. A bit 0 of 1 makes the output 1.
- R3: While only ones have arrived since start, the output stays 1. This includes a word of all ones over all 32 bits.
- R4: After the first zero, each zero run must have exactly the learned width. A one that arrives too early, or a zero beyond the width, drops the output to 0.
- R5: The runs keep alternating with the learned width up to bit 31. A final run cut short by the word boundary still matches.
- R6: Every stripe width from 1 to 31 is accepted: the ideal pattern for each width keeps the output at 1 for all 32 bits.
- R7: Once a bit disagrees with the expected pattern, the output stays 0 for the rest of the word, even if later bits follow the pattern again.
- R8: A start pulse restarts the check from that bit, whatever state earlier bits left behind, including partway through a word.
- R9: The output is a register. The value read after the rising edge that follows a bit covers every bit up to and including that one, and it does not change before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock, one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | High together with bit 0 of a word |
| din | input | 1 | Serial data bit, least significant bit first |
| match | output | 1 | 1 while all bits received so far fit the stripe pattern |

## Verification
The assertions assume that a new bit arrives on every clock after a start pulse, so the internal down-counter advances once per edge. They also assume that start is a level sampled at the same edge as its bit 0. The bench drives start and din together on the falling edge and keeps start high for exactly one cycle per word. When it aborts a word partway through, it presents a fresh start with its bit 0, so the assumption of one bit per clock still holds.

// File: rtl/stripe_pkg.sv
package stripe_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LEARN = 2'd1,
        PH_TRACK = 2'd2,
        PH_FAIL  = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   match;
    } ctrl_state_t;

endpackage

// File: rtl/stripe_width_learner.sv
module stripe_width_learner #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             learn_en,
    input  logic             din,
    output logic [CNT_W-1:0] width
);
    localparam logic [CNT_W-1:0] WIDTH_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] width_d, width_q;

    always_comb begin
        width_d = width_q;
        if (start) begin
            width_d = din ? CNT_W'(1) : '0;
        end else if (learn_en && din && width_q != WIDTH_MAX) begin
            width_d = width_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) width_q <= '0;
        else        width_q <= width_d;
    end

    assign width = width_q;

    // R3: a one while learning grows the width by one (below saturation)
    assert_width_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && learn_en && din && width_q != WIDTH_MAX) |=> (width_q == $past(width_q) + CNT_W'(1)));

    // R8: start with a one always restarts the width at one
    assert_width_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && din) |=> (width_q == CNT_W'(1)));
endmodule

// File: rtl/stripe_phase_tracker.sv
module stripe_phase_tracker #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter,
    input  logic             step,
    input  logic [CNT_W-1:0] width,
    output logic             expect_bit,
    output logic [CNT_W-1:0] remain
);
    typedef struct packed {
        logic             exp_bit;
        logic [CNT_W-1:0] rem;
    } trk_state_t;

    trk_state_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (enter) begin
            // the bit being accepted is the first zero of the first zero run
            if (width == CNT_W'(1)) begin
                trk_d.exp_bit = 1'b1;
                trk_d.rem     = width;
            end else begin
                trk_d.exp_bit = 1'b0;
                trk_d.rem     = width - CNT_W'(1);
            end
        end else if (step) begin
            if (trk_q.rem == CNT_W'(1)) begin
                trk_d.exp_bit = ~trk_q.exp_bit;
                trk_d.rem     = width;
            end else begin
                trk_d.rem     = trk_q.rem - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign expect_bit = trk_q.exp_bit;
    assign remain     = trk_q.rem;

    // R5: while tracking, the remaining count of the run is never empty
    assert_rem_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (trk_q.rem != '0));

    // R5: when a run is used up, the expected value flips on the next bit
    assert_phase_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !enter && trk_q.rem == CNT_W'(1)) |=> (trk_q.exp_bit != $past(trk_q.exp_bit)));
endmodule

// File: rtl/stripe_checker.sv
module stripe_checker #(
    parameter int WORD_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic din,
    output logic match
);
    import stripe_pkg::*;

    localparam int CNT_W = $clog2(WORD_BITS + 1);

    ctrl_state_t      st_d, st_q;
    logic [CNT_W-1:0] width;
    logic [CNT_W-1:0] remain;
    logic             expect_bit;
    logic             learn_en;
    logic             enter;
    logic             step;

    assign learn_en = (st_q.phase == PH_LEARN);
    assign enter    = !start && (st_q.phase == PH_LEARN) && !din;
    assign step     = !start && (st_q.phase == PH_TRACK) && (din == expect_bit);

    stripe_width_learner #(.CNT_W(CNT_W)) u_learner (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .learn_en (learn_en),
        .din      (din),
        .width    (width)
    );

    stripe_phase_tracker #(.CNT_W(CNT_W)) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter      (enter),
        .step       (step),
        .width      (width),
        .expect_bit (expect_bit),
        .remain     (remain)
    );

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.phase = din ? PH_LEARN : PH_FAIL;
            st_d.match = din;
        end else begin
            unique case (st_q.phase)
                PH_IDLE: begin
                    st_d.match = 1'b0;
                end
                PH_LEARN: begin
                    st_d.match = 1'b1;
                    if (!din) st_d.phase = PH_TRACK;
                end
                PH_TRACK: begin
                    if (din == expect_bit) begin
                        st_d.match = 1'b1;
                    end else begin
                        st_d.phase = PH_FAIL;
                        st_d.match = 1'b0;
                    end
                end
                default: begin
                    st_d.match = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.match <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign match = st_q.match;

    // R1: without a start pulse the idle checker keeps the flag low
    assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && !start) |=> !match);

    // R2: bit 0 decides the first verdict
    assert_bit0_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !din) |=> !match);
    assert_bit0_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && din) |=> match);

    // R4: a disagreeing bit during tracking drops the flag
    assert_mismatch_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && st_q.phase == PH_TRACK && din != expect_bit) |=> !match);

    // R7: a failed word stays failed until a new start
    assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_FAIL && !start) |=> (!match && st_q.phase == PH_FAIL));

    // R5: tracking never uses a run longer than the learned width
    assert_rem_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_TRACK) |-> (remain <= width && width != '0));
endmodule

// File: tb/tb_stripe_checker.sv
module tb_stripe_checker;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic din = 1'b0;
    logic match;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    stripe_checker dut (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .din   (din),
        .match (match)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] ideal_word(int w);
        logic [31:0] v;
        for (int i = 0; i < 32; i++) v[i] = (((i / w) % 2) == 0);
        return v;
    endfunction

    // expected verdict after the first k bits of v
    function automatic logic ref_match(logic [31:0] v, int k);
        int w;
        if (!v[0]) return 1'b0;
        w = 0;
        while (w < k && v[w]) w++;
        if (w == k) return 1'b1;
        for (int i = 0; i < k; i++)
            if (v[i] != (((i / w) % 2) == 0)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(string req, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0b expected=%0b at %0t", req, got, exp, $time);
        end
    endtask

    // sends the lowest n bits of v with start on bit 0, checking after each bit
    task automatic send_bits(string req, logic [31:0] v, int n);
        for (int i = 0; i < n; i++) begin
            start = (i == 0);
            din   = v[i];
            @(negedge clk);
            check(req, match, ref_match(v, i + 1));
        end
        start = 1'b0;
    endtask

    task automatic test_reset();
        check("R1", match, 1'b0);
        for (int i = 0; i < 6; i++) begin
            din = 1'b1;
            @(negedge clk);
            check("R1", match, 1'b0);
        end
    endtask

    task automatic test_all_widths();
        for (int w = 1; w < 32; w++) begin
            send_bits("R6", ideal_word(w), 32);
            check("R5", match, 1'b1);
        end
    endtask

    task automatic test_all_ones();
        send_bits("R3", 32'hFFFF_FFFF, 32);
        check("R3", match, 1'b1);
    endtask

    task automatic test_bit0_zero();
        send_bits("R2", 32'h0000_0000, 32);
        check("R2", match, 1'b0);
        send_bits("R2", ideal_word(3) << 1, 32);
        check("R2", match, 1'b0);
    endtask

    task automatic test_zero_run_length();
        // width 3, early one at bit 4
        send_bits("R4", ideal_word(3) | 32'h0000_0010, 32);
        check("R4", match, 1'b0);
        // width 2, zero run stretched by one at bit 4
        send_bits("R4", ideal_word(2) & ~32'h0000_0010, 32);
        check("R4", match, 1'b0);
    endtask

    task automatic test_sticky();
        // width 4, single bad bit at 9; every other bit is ideal
        send_bits("R7", ideal_word(4) ^ 32'h0000_0200, 32);
        check("R7", match, 1'b0);
    endtask

    task automatic test_restart();
        send_bits("R8", ideal_word(5) ^ 32'h0000_0004, 12);
        send_bits("R8", ideal_word(7), 32);
        check("R8", match, 1'b1);
        send_bits("R8", ideal_word(2), 10);
        send_bits("R8", 32'h0000_0000, 3);
        check("R8", match, 1'b0);
    endtask

    task automatic test_registered();
        start = 1'b1; din = 1'b0;
        #1 check("R9", match, 1'b1);
        @(negedge clk);
        check("R9", match, 1'b0);
        start = 1'b1; din = 1'b1;
        #1 check("R9", match, 1'b0);
        @(negedge clk);
        check("R9", match, 1'b1);
        start = 1'b0;
    endtask

    task automatic test_mixed();
        logic [31:0] v = 32'h1234_5679;
        for (int t = 0; t < 20; t++) begin
            v = {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
            send_bits("R5", (t % 2) ? (ideal_word(t + 1) ^ (v & 32'h0101_0000)) : v, 32);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_all_widths();
        test_all_ones();
        test_bit0_zero();
        test_zero_run_length();
        test_sticky();
        test_restart();
        send_bits("R9", ideal_word(3), 32);
        test_registered();
        test_mixed();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule